// File: doc/BRIEF.md
# Hibernation Wake-Count Power Sequencer

This block lives in the always-on part of the chip and is clocked by the 32 kHz slow clock. It drives the enable pin of the regulator that powers everything else. Software first loads a 32-bit wake count through a small write port in the fast bus domain. It then raises a hibernate request. The sequencer pulls the regulator enable low, which removes power from the rest of the chip. It keeps the enable low for the programmed number of slow-clock cycles and then drives it high again so the chip boots.

The request level is registered in the bus domain and passed through a two-flop synchroniser into the slow domain. Only a fresh rising edge of that synchronised level starts a sleep. Once the enable is low, the sequencer ignores further request activity until the timer expires. When the timer expires, the sequencer sets a wake-source flag. A synchronised copy of that flag reaches the bus domain, so the restarted software can see that the timer caused the wake.

The count write port uses a valid/ready handshake. A word is taken on a bus clock edge where `wr_valid_i` and `wr_ready_o` are both high. The port applies back-pressure by holding `wr_ready_o` low while the request is asserted, so the count cannot change while the slow domain may be sampling it. A producer must hold `wr_valid_i` and `wr_count_i` steady until the word is accepted. The request and the flag are plain level pins.

Top module: `hib_wake_seq`

## Requirements
- R1: After `rst_aon_n` is released, `reg_en_o` is 1. After both resets, `wake_flag_o` is 0 and, with `hib_req_i` low, `wr_ready_o` is 1.
- R2: A count word is stored only on a `clk_bus` edge with `wr_valid_i` and `wr_ready_o` both high. `wr_ready_o` is 0 from the bus cycle after `hib_req_i` rises until the bus cycle after it falls. A word offered while `wr_ready_o` is 0 is not stored.
- R3: When `hib_req_i` rises just after a falling `clk_aon` edge and had been low long enough for the synchroniser to settle, `reg_en_o` reads 0 at the third following falling `clk_aon` edge.
- R4: Once it falls, `reg_en_o` stays 0 for exactly N `clk_aon` cycles, where N is the stored count and N is at least 1.
- R5: A stored count of 0 gives a low pulse of exactly one `clk_aon` cycle.
- R6: Request edges that arrive while `reg_en_o` is 0 neither lengthen the pulse nor start another pulse.
- R7: A request that is already high when `rst_aon_n` is released starts no sleep. The request must fall and rise again to start one.
- R8: The wake flag becomes 1 in the cycle in which `reg_en_o` returns high after a timed sleep, and is cleared when a new sleep starts. `wake_flag_o` shows this flag within four `clk_bus` cycles.
- R9: A request held high through a whole sleep causes no second sleep after the wake.
- R10: A request edge that arrives in the synchronised domain in the same cycle the timer expires is dropped. An edge one cycle later starts a new sleep, so `reg_en_o` is high for exactly one cycle between the two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast bus-domain clock |
| rst_bus_n | input | 1 | Asynchronous active-low reset of the bus domain |
| wr_valid_i | input | 1 | A count word is offered |
| wr_ready_o | output | 1 | The count register can accept a word |
| wr_count_i | input | CNT_W | Wake count, in slow-clock cycles |
| hib_req_i | input | 1 | Hibernate request level (bus domain) |
| clk_aon | input | 1 | Always-on 32 kHz clock |
| rst_aon_n | input | 1 | Asynchronous active-low power-on reset of the always-on domain |
| reg_en_o | output | 1 | Regulator enable; low while the chip sleeps |
| wake_flag_o | output | 1 | The last wake came from the timer (bus-domain copy) |

## Verification
Two slow-domain events can coincide: the timer expiring and a new synchronised request edge arriving. The bench first measures the cycle in which the pulse started. It then raises the request so that the edge reaches the slow domain either exactly at expiry or one cycle after it, using the fixed three-cycle path from the request pin to the enable. When the edge lands on the expiry cycle, the bench expects only one pulse and a steady high enable afterwards. When the edge lands one cycle later, it expects a second pulse of the same width after a high gap of exactly one cycle. On the bus side, a count write is offered while the request is rising. The bench judges this by the width of the next sleep.

// File: rtl/hib_pkg.sv
package hib_pkg;

  typedef enum logic {
    HS_AWAKE  = 1'b0,
    HS_ASLEEP = 1'b1
  } hib_state_e;

  localparam int unsigned HIB_SYNC_STAGES = 2;

endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES*W){RST_VAL}};
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES*W){RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hib_cfg_port.sv
module hib_cfg_port #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_bus,
  input  logic             rst_bus_n,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [CNT_W-1:0] wr_count_i,
  input  logic             hib_req_i,
  output logic             req_q_o,
  output logic [CNT_W-1:0] count_q_o
);

  logic             req_q;
  logic [CNT_W-1:0] count_q;
  logic             take;

  assign wr_ready_o = ~req_q;
  assign take       = wr_valid_i & wr_ready_o;

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n) begin
      req_q   <= 1'b0;
      count_q <= '0;
    end else begin
      req_q <= hib_req_i;
      if (take) count_q <= wr_count_i;
    end
  end

  assign req_q_o   = req_q;
  assign count_q_o = count_q;

endmodule

// File: rtl/hib_wake_timer.sv
module hib_wake_timer
  import hib_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_aon,
  input  logic             rst_aon_n,
  input  logic             req_sync_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             reg_en_o,
  output logic             wake_src_o,
  output logic [CNT_W-1:0] remain_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  hib_state_e       state_q;
  logic             prev_q;
  logic             en_q;
  logic             flag_q;
  logic [CNT_W-1:0] rem_q;
  logic             req_edge;
  logic [CNT_W-1:0] load_val;

  assign req_edge = req_sync_i & ~prev_q;
  assign load_val = (count_i == '0) ? ONE : count_i;

  always_ff @(posedge clk_aon or negedge rst_aon_n) begin
    if (!rst_aon_n) begin
      state_q <= HS_AWAKE;
      prev_q  <= 1'b1;
      en_q    <= 1'b1;
      flag_q  <= 1'b0;
      rem_q   <= '0;
    end else begin
      prev_q <= req_sync_i;
      unique case (state_q)
        HS_AWAKE: begin
          if (req_edge) begin
            state_q <= HS_ASLEEP;
            en_q    <= 1'b0;
            flag_q  <= 1'b0;
            rem_q   <= load_val;
          end
        end
        HS_ASLEEP: begin
          if (rem_q == ONE) begin
            state_q <= HS_AWAKE;
            en_q    <= 1'b1;
            flag_q  <= 1'b1;
            rem_q   <= '0;
          end else begin
            rem_q <= rem_q - ONE;
          end
        end
        default: state_q <= HS_AWAKE;
      endcase
    end
  end

  assign reg_en_o   = en_q;
  assign wake_src_o = flag_q;
  assign remain_o   = rem_q;

endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq
  import hib_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = HIB_SYNC_STAGES
) (
  input  logic             clk_bus,
  input  logic             rst_bus_n,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [CNT_W-1:0] wr_count_i,
  input  logic             hib_req_i,
  input  logic             clk_aon,
  input  logic             rst_aon_n,
  output logic             reg_en_o,
  output logic             wake_flag_o
);

  logic             req_bus_q;
  logic [CNT_W-1:0] cfg_count;
  logic             req_aon;
  logic             wake_src_aon;
  logic [CNT_W-1:0] remain_w;

  hib_cfg_port #(.CNT_W(CNT_W)) cfg_i (
    .clk_bus    (clk_bus),
    .rst_bus_n  (rst_bus_n),
    .wr_valid_i (wr_valid_i),
    .wr_ready_o (wr_ready_o),
    .wr_count_i (wr_count_i),
    .hib_req_i  (hib_req_i),
    .req_q_o    (req_bus_q),
    .count_q_o  (cfg_count)
  );

  hib_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) req_sync_i (
    .clk   (clk_aon),
    .rst_n (rst_aon_n),
    .d     (req_bus_q),
    .q     (req_aon)
  );

  hib_wake_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_aon    (clk_aon),
    .rst_aon_n  (rst_aon_n),
    .req_sync_i (req_aon),
    .count_i    (cfg_count),
    .reg_en_o   (reg_en_o),
    .wake_src_o (wake_src_aon),
    .remain_o   (remain_w)
  );

  hib_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) flag_sync_i (
    .clk   (clk_bus),
    .rst_n (rst_bus_n),
    .d     (wake_src_aon),
    .q     (wake_flag_o)
  );

endmodule

// File: rtl/hib_wake_seq_chk.sv
module hib_wake_seq_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_bus,
  input logic             rst_bus_n,
  input logic             clk_aon,
  input logic             rst_aon_n,
  input logic             wr_valid_i,
  input logic             wr_ready_o,
  input logic             hib_req_i,
  input logic             reg_en_o,
  input logic [CNT_W-1:0] cfg_count,
  input logic             wake_src_aon,
  input logic [CNT_W-1:0] remain_w
);

  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] exp_len;

  always_ff @(posedge clk_aon or negedge rst_aon_n) begin
    if (!rst_aon_n) begin
      low_len <= '0;
      exp_len <= '0;
    end else begin
      low_len <= reg_en_o ? '0 : low_len + 1'b1;
      if (!reg_en_o && $past(reg_en_o))
        exp_len <= (cfg_count == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : cfg_count;
    end
  end

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_valid_i && !wr_ready_o) |=> $stable(cfg_count)); // R2
  AST_READY_DROPS: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    hib_req_i |=> !wr_ready_o); // R2
  AST_PULSE_WIDTH: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
    $rose(reg_en_o) |-> (low_len == exp_len)); // R4
  AST_STEADY_COUNTDOWN: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
    (!reg_en_o && $past(!reg_en_o)) |-> (remain_w == $past(remain_w) - 1'b1)); // R6
  AST_FLAG_ON_WAKE: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
    $rose(reg_en_o) |-> wake_src_aon); // R8
  AST_FLAG_CLEARED_ON_SLEEP: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
    $fell(reg_en_o) |-> !wake_src_aon); // R8

endmodule

bind hib_wake_seq hib_wake_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_bus      (clk_bus),
  .rst_bus_n    (rst_bus_n),
  .clk_aon      (clk_aon),
  .rst_aon_n    (rst_aon_n),
  .wr_valid_i   (wr_valid_i),
  .wr_ready_o   (wr_ready_o),
  .hib_req_i    (hib_req_i),
  .reg_en_o     (reg_en_o),
  .cfg_count    (cfg_count),
  .wake_src_aon (wake_src_aon),
  .remain_w     (remain_w)
);

// File: tb/hib_wake_seq_tb.sv
module hib_wake_seq_tb_top;

  localparam int CNT_W = 32;

  logic             clk_bus = 1'b0;
  logic             clk_aon = 1'b0;
  logic             rst_bus_n = 1'b0;
  logic             rst_aon_n = 1'b0;
  logic             wr_valid_i = 1'b0;
  logic [CNT_W-1:0] wr_count_i = '0;
  logic             hib_req_i = 1'b0;
  logic             wr_ready_o;
  logic             reg_en_o;
  logic             wake_flag_o;

  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;
  logic [1:0] div = 2'd0;

  int cur_low = 0, hi_run = 0, last_w = 0, last_gap = 0, pulses = 0;

  hib_wake_seq #(.CNT_W(CNT_W)) dut_i (
    .clk_bus     (clk_bus),
    .rst_bus_n   (rst_bus_n),
    .wr_valid_i  (wr_valid_i),
    .wr_ready_o  (wr_ready_o),
    .wr_count_i  (wr_count_i),
    .hib_req_i   (hib_req_i),
    .clk_aon     (clk_aon),
    .rst_aon_n   (rst_aon_n),
    .reg_en_o    (reg_en_o),
    .wake_flag_o (wake_flag_o)
  );

  always #4 clk_bus = ~clk_bus;

  always @(negedge clk_bus) begin
    div <= div + 2'd1;
    if (div == 2'd3) clk_aon <= ~clk_aon;
  end

  always @(negedge clk_aon) begin
    if (!rst_aon_n) begin
      cur_low = 0; hi_run = 0;
    end else if (!reg_en_o) begin
      if (cur_low == 0) last_gap = hi_run;
      cur_low++; hi_run = 0;
    end else begin
      if (cur_low > 0) begin last_w = cur_low; pulses++; end
      cur_low = 0; hi_run++;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_bus) begin
    wd++;
    if (wd == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d", wd, 150000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_width(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic write_count(input int n);
    @(negedge clk_bus);
    wr_valid_i = 1'b1; wr_count_i = CNT_W'(n);
    while (!wr_ready_o) @(negedge clk_bus);
    @(negedge clk_bus);
    wr_valid_i = 1'b0;
  endtask

  task automatic aon_wait(input int k);
    repeat (k) @(negedge clk_aon);
  endtask

  task automatic wait_pulses(input int target);
    for (int i = 0; i < 400 && pulses < target; i++) @(negedge clk_aon);
  endtask

  // raise at a falling aon edge, count edges until the enable is seen low
  task automatic raise_and_time(output int lat);
    @(negedge clk_aon);
    hib_req_i = 1'b1;
    lat = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_aon);
      lat++;
      if (!reg_en_o) break;
    end
  endtask

  task automatic sleep_once(input int n, input string tag);
    int lat;
    int p0;
    p0 = pulses;
    aon_wait(4);
    raise_and_time(lat);
    chk(lat == 3, "R3 start latency", lat, 3);
    hib_req_i = 1'b0;
    @(negedge clk_aon);
    chk(wake_flag_o == 1'b0 || !reg_en_o == 1'b0, "R8 flag cleared in sleep", wake_flag_o, 0);
    wait_pulses(p0 + 1);
    chk(last_w == exp_width(n), tag, last_w, exp_width(n));
    repeat (2) @(negedge clk_bus);
    chk(wake_flag_o == 1'b1, "R8 flag after wake", wake_flag_o, 1);
  endtask

  initial begin
    int n, p0, lat;
    void'($urandom(32'd5150));
    aon_wait(4);
    rst_bus_n = 1'b1; rst_aon_n = 1'b1;
    @(negedge clk_bus);
    // R1 reset state
    chk(reg_en_o == 1'b1, "R1 enable after reset", reg_en_o, 1);
    chk(wake_flag_o == 1'b0, "R1 flag after reset", wake_flag_o, 0);
    chk(wr_ready_o == 1'b1, "R1 ready after reset", wr_ready_o, 1);

    // R4: random widths
    for (int t = 0; t < 10; t++) begin
      n = int'($urandom_range(0, 30));
      write_count(n);
      sleep_once(n, (n == 0) ? "R5 zero count width" : "R4 pulse width");
    end

    // R5: directed zero
    write_count(0);
    sleep_once(0, "R5 zero count width");

    // R6: request toggles while asleep
    write_count(12);
    p0 = pulses;
    aon_wait(4);
    raise_and_time(lat);
    hib_req_i = 1'b0; aon_wait(3);
    hib_req_i = 1'b1; aon_wait(3);
    hib_req_i = 1'b0;
    wait_pulses(p0 + 1);
    aon_wait(8);
    chk(last_w == 12, "R6 width with toggles", last_w, 12);
    chk(pulses == p0 + 1, "R6 single pulse", pulses - p0, 1);

    // R9: request held high across the whole sleep
    write_count(5);
    p0 = pulses;
    aon_wait(4);
    raise_and_time(lat);
    wait_pulses(p0 + 1);
    aon_wait(16);
    chk(pulses == p0 + 1 && reg_en_o, "R9 no re-entry", pulses - p0, 1);
    hib_req_i = 1'b0;

    // R2: write offered while request high is refused
    write_count(3);
    p0 = pulses;
    aon_wait(4);
    raise_and_time(lat);
    @(negedge clk_bus);
    wr_valid_i = 1'b1; wr_count_i = CNT_W'(9);
    @(negedge clk_bus);
    chk(wr_ready_o == 1'b0, "R2 ready low under request", wr_ready_o, 0);
    repeat (4) @(negedge clk_bus);
    wr_valid_i = 1'b0;
    hib_req_i = 1'b0;
    wait_pulses(p0 + 1);
    sleep_once(3, "R2 refused write kept old count");

    // R10a: edge lands on the expiry cycle
    write_count(8);
    p0 = pulses;
    aon_wait(4);
    raise_and_time(lat);
    hib_req_i = 1'b0;
    aon_wait(8 - 3);
    hib_req_i = 1'b1;
    wait_pulses(p0 + 1);
    aon_wait(10);
    chk(pulses == p0 + 1, "R10 edge at expiry dropped", pulses - p0, 1);
    chk(reg_en_o == 1'b1, "R10 enable stays high", reg_en_o, 1);
    hib_req_i = 1'b0;

    // R10b: edge one cycle after expiry
    p0 = pulses;
    aon_wait(4);
    raise_and_time(lat);
    hib_req_i = 1'b0;
    aon_wait(8 - 2);
    hib_req_i = 1'b1;
    wait_pulses(p0 + 2);
    chk(pulses == p0 + 2, "R10 late edge restarts", pulses - p0, 2);
    chk(last_gap == 1, "R10 one-cycle gap", last_gap, 1);
    chk(last_w == 8, "R10 second width", last_w, 8);
    hib_req_i = 1'b0;
    aon_wait(4);

    // R7: request already high at power-on reset release
    @(negedge clk_aon);
    rst_aon_n = 1'b0;
    hib_req_i = 1'b1;
    aon_wait(3);
    rst_aon_n = 1'b1;
    p0 = pulses;
    @(negedge clk_aon);
    chk(reg_en_o == 1'b1, "R1 enable after aon reset", reg_en_o, 1);
    aon_wait(10);
    chk(pulses == p0 && reg_en_o, "R7 stale request ignored", pulses - p0, 0);
    repeat (4) @(negedge clk_bus);
    chk(wake_flag_o == 1'b0, "R1 flag after aon reset", wake_flag_o, 0);
    hib_req_i = 1'b0;
    sleep_once(8, "R7 fresh edge sleeps");

    summary();
  end

endmodule